// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces a processor reset from three digital requests: a supply-good flag, an active-low manual reset request, and an active-low watchdog trip that shares the manual path. Reset is held for as long as any request is present. Once the last request goes away, reset stays asserted for a fixed hold period counted in clock cycles. Any new request that arrives while a reset is still running reloads the hold period. A single press therefore always gives a pulse of at least the hold length, and a bouncing pushbutton gives one continuous pulse without any separate debounce logic.

The block has two registered outputs, one active-high and one active-low, plus a small code that names the source that most recently started or restarted a reset. A power-on input initialises the block asynchronously and forces reset on. The block then runs a complete hold period before it releases reset for the first time. The hold length comes from the clock frequency and a millisecond value. A simulation switch replaces it with a short cycle count.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `sys_rst`=1, `sys_rst_n`=0 and `rst_cause`=2'b00. If the supply is good and no request is present when `por_n` rises, `sys_rst` falls after rising clock edge number HOLD+SYNC_STAGES, counted from the first edge after the release.
- R2: While `pwr_ok` is low, `sys_rst` stays high. After `pwr_ok` returns high, `sys_rst` falls after edge number HOLD+2, counted from the first edge after the return.
- R3: A `pwr_ok` low pulse of L≥1 cycles while the block is running raises `sys_rst` after the third rising edge from the start of the pulse. The reset lasts L+HOLD−1 cycles, so it is never shorter than HOLD.
- R4: `man_rst_n` low (active low) starts the same sequence as R3, with the same timing.
- R5: `wdt_trip_n` low (active low) feeds the manual path and gives the same sequence and timing as R3.
- R6: A request that arrives while a reset is still running restarts the hold period. `sys_rst` stays high without a gap and falls HOLD+2 edges after the last request is released.
- R7: `sys_rst_n` is always the exact complement of `sys_rst`.
- R8: `rst_cause` takes a new value on every request onset, including onsets during a running reset, and otherwise holds its value. The codes are 2'b01 for supply, 2'b10 for manual and 2'b11 for watchdog. When onsets fall in the same cycle, supply wins over manual and manual wins over watchdog.
- R9: A bouncing manual request (any on/off pattern whose off-gaps are shorter than HOLD−1 cycles) gives one continuous reset. That reset ends HOLD+2 edges after the final release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| pwr_ok | input | 1 | Supply-good flag, high when the supply is in range |
| man_rst_n | input | 1 | Manual reset request, active low |
| wdt_trip_n | input | 1 | Watchdog trip into the manual path, active low |
| sys_rst | output | 1 | Reset output, active high |
| sys_rst_n | output | 1 | Reset output, active low |
| rst_cause | output | 2 | Source of the most recent reset start: 00 power-on, 01 supply, 10 manual, 11 watchdog |

## Verification
The bench builds the block with SIM_HOLD=1, SIM_CYCLES=6 and SYNC_STAGES=2, so a whole hold window lasts only a few cycles. Pulse lengths from one cycle to beyond the hold are swept for each of the three sources. Restart gaps are swept across every cycle of a running hold, so each position of a new request relative to the down-count is exercised. Same-cycle onsets from pairs of sources and a chattering pushbutton pattern are also driven, and each expected edge count is computed from the pulse and gap lengths.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  typedef enum logic [1:0] {
    CAUSE_POR    = 2'b00,
    CAUSE_SUPPLY = 2'b01,
    CAUSE_MANUAL = 2'b10,
    CAUSE_WDOG   = 2'b11
  } cause_e;

  // number of clock cycles in one hold window
  function automatic int unsigned hold_cycles(int unsigned clk_hz, int unsigned hold_ms,
                                              bit sim, int unsigned sim_cycles);
    if (sim) return sim_cycles;
    return (clk_hz / 1000) * hold_ms;
  endfunction

  // counter width able to hold the value n
  function automatic int unsigned cnt_width(int unsigned n);
    int unsigned w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // fixed priority on same-cycle onsets, otherwise keep the previous code
  function automatic cause_e pick_cause(logic sup_ev, logic man_ev, logic wd_ev, cause_e prev);
    if (sup_ev) return CAUSE_SUPPLY;
    if (man_ev) return CAUSE_MANUAL;
    if (wd_ev)  return CAUSE_WDOG;
    return prev;
  endfunction

endpackage

// File: rtl/rst_sup_sync.sv
`timescale 1ns/1ps
module rst_sup_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rst_sup_hold_timer.sv
`timescale 1ns/1ps
module rst_sup_hold_timer #(
  parameter int unsigned HOLD = 16,
  parameter int unsigned CW   = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic rst_o,
  output logic rst_n_o
);

  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          rst_q, rst_nq;
  logic          load_ev, tick_ev;

  assign load_ev = trig;
  assign tick_ev = !trig && (cnt != '0);

  always_comb begin
    if (load_ev)      cnt_nxt = HOLD_V;
    else if (tick_ev) cnt_nxt = cnt - 1'b1;
    else              cnt_nxt = cnt;
  end

  // two separate output flops so neither is a gate away from the other
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt    <= HOLD_V;
      rst_q  <= 1'b1;
      rst_nq <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      rst_q  <= (cnt_nxt != '0);
      rst_nq <= (cnt_nxt == '0);
    end
  end

  assign rst_o   = rst_q;
  assign rst_n_o = rst_nq;

  AST_RELOAD_ON_REQ: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> (cnt == HOLD_V));                                          // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!por_n)
    (!trig && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));                // R3
  AST_HELD_WHILE_REQ: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> rst_q);                                                     // R2
  AST_FULL_WINDOW_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_q) |-> (cnt == HOLD_V));                                   // R3
  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!por_n)
    rst_q != rst_nq);                                                    // R7

endmodule

// File: rtl/rst_sup_cause.sv
`timescale 1ns/1ps
module rst_sup_cause
  import rst_sup_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NSRC-1:0] act,
  output cause_e          cause
);

  logic [NSRC-1:0] onset;
  cause_e          cause_q;

  // seen flags start as "already active" so power-on itself is no onset
  for (genvar i = 0; i < NSRC; i++) begin : g_edge
    logic seen_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) seen_q <= 1'b1;
      else        seen_q <= act[i];
    end
    assign onset[i] = act[i] & ~seen_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= CAUSE_POR;
    else        cause_q <= pick_cause(onset[0], onset[1], onset[2], cause_q);
  end

  assign cause = cause_q;

  AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    (onset == '0) |=> $stable(cause_q));                                 // R8
  AST_CAUSE_SUPPLY_WINS: assert property (@(posedge clk) disable iff (!por_n)
    onset[0] |=> (cause_q == CAUSE_SUPPLY));                             // R8
  AST_CAUSE_ONSET_ONEHOT_WD: assert property (@(posedge clk) disable iff (!por_n)
    (onset == 3'b100) |=> (cause_q == CAUSE_WDOG));                      // R8

endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned HOLD_MS     = 200,
  parameter bit          SIM_HOLD    = 1'b0,
  parameter int unsigned SIM_CYCLES  = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pwr_ok,
  input  logic       man_rst_n,
  input  logic       wdt_trip_n,
  output logic       sys_rst,
  output logic       sys_rst_n,
  output logic [1:0] rst_cause
);

  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_MS, SIM_HOLD, SIM_CYCLES);
  localparam int unsigned CW       = cnt_width(HOLD_CYC);
  localparam int          NSRC     = 3;
  // supply starts "bad", manual and watchdog start inactive
  localparam logic [NSRC-1:0] SYNC_INIT = 3'b110;

  logic [NSRC-1:0] raw_in, sync_in, req_act;
  logic            any_req;
  cause_e          cause_w;

  assign raw_in = {wdt_trip_n, man_rst_n, pwr_ok};

  rst_sup_sync #(.W(NSRC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_INIT)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  // every source is active low after synchronisation
  assign req_act = ~sync_in;
  assign any_req = |req_act;

  rst_sup_hold_timer #(.HOLD(HOLD_CYC), .CW(CW)) u_hold (
    .clk     (clk),
    .por_n   (por_n),
    .trig    (any_req),
    .rst_o   (sys_rst),
    .rst_n_o (sys_rst_n)
  );

  rst_sup_cause #(.NSRC(NSRC)) u_cause (
    .clk   (clk),
    .por_n (por_n),
    .act   (req_act),
    .cause (cause_w)
  );

  assign rst_cause = cause_w;

  AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    req_act[0] |=> sys_rst);                                             // R2
  AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    req_act[1] |=> sys_rst);                                             // R4
  AST_WDOG_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    req_act[2] |=> sys_rst);                                             // R5

endmodule

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;

  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, pwr_ok = 1'b1, man_rst_n = 1'b1, wdt_trip_n = 1'b1;
  logic sys_rst, sys_rst_n;
  logic [1:0] rst_cause;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_supervisor #(.SIM_HOLD(1'b1), .SIM_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .pwr_ok(pwr_ok), .man_rst_n(man_rst_n),
    .wdt_trip_n(wdt_trip_n), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .rst_cause(rst_cause)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mask bit0 supply, bit1 manual, bit2 watchdog
  task automatic set_src(int mask, bit active);
    if (mask[0]) pwr_ok     = !active;
    if (mask[1]) man_rst_n  = !active;
    if (mask[2]) wdt_trip_n = !active;
  endtask

  task automatic idle();
    repeat (HOLD + 8) @(negedge clk);
  endtask

  // first request on m1 for l1 cycles; optional second on m2 starting gap cycles after release
  task automatic run_seq(int m1, int l1, int m2, int gap, int l2, string req, int exp_cause);
    int rise_k = -1, fall_k = -1, bad_c = 0, last_rel, kmax;
    last_rel = (m2 != 0) ? l1 + gap + l2 : l1;
    kmax = last_rel + HOLD + 12;
    @(negedge clk);
    set_src(m1, 1'b1);
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      if (sys_rst_n !== ~sys_rst) bad_c++;
      if (sys_rst && rise_k < 0) rise_k = k;
      if (!sys_rst && rise_k > 0 && fall_k < 0) fall_k = k;
      if (k == l1) set_src(m1, 1'b0);
      if (m2 != 0 && k == l1 + gap) set_src(m2, 1'b1);
      if (m2 != 0 && k == last_rel) set_src(m2, 1'b0);
    end
    check(rise_k == 3, {req, " onset edge"}, rise_k, 3);
    check(fall_k == last_rel + HOLD + 2, {req, " release edge"}, fall_k, last_rel + HOLD + 2);
    check(bad_c == 0, "R7 complement mismatches", bad_c, 0);
    check(int'(rst_cause) == exp_cause, "R8 cause code", int'(rst_cause), exp_cause);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int fall_k;
    logic [11:0] pat;
    int last_on;
    // R1: power-on state
    repeat (3) @(negedge clk);
    check(sys_rst == 1'b1, "R1 sys_rst during por", int'(sys_rst), 1);
    check(sys_rst_n == 1'b0, "R1 sys_rst_n during por", int'(sys_rst_n), 0);
    check(rst_cause == 2'b00, "R1 cause during por", int'(rst_cause), 0);
    por_n = 1'b1;
    fall_k = -1;
    for (int k = 1; k <= HOLD + 10; k++) begin
      @(negedge clk);
      if (!sys_rst && fall_k < 0) fall_k = k;
    end
    check(fall_k == HOLD + 2, "R1 first release edge", fall_k, HOLD + 2);
    check(rst_cause == 2'b00, "R1 cause after power-on", int'(rst_cause), 0);

    // R2/R3: supply dips of every length up to beyond the hold, plus a long one
    for (int l = 1; l <= HOLD + 3; l++) run_seq(1, l, 0, 0, 0, "R3 supply dip", 1);
    run_seq(1, 30, 0, 0, 0, "R2 supply held low", 1);
    // R4 manual, R5 watchdog
    for (int l = 1; l <= HOLD + 3; l++) run_seq(2, l, 0, 0, 0, "R4 manual", 2);
    for (int l = 1; l <= HOLD + 3; l++) run_seq(4, l, 0, 0, 0, "R5 watchdog", 3);
    // R8: same-cycle onsets
    run_seq(3, 2, 0, 0, 0, "R8 supply+manual", 1);
    run_seq(6, 2, 0, 0, 0, "R8 manual+watchdog", 2);
    run_seq(5, 2, 0, 0, 0, "R8 supply+watchdog", 1);
    // R6: restart at every gap inside a running hold, cause follows the new source
    for (int g = 1; g <= HOLD - 1; g++) run_seq(1, 2, 2, g, 1, "R6 restart supply->manual", 2);
    for (int g = 1; g <= HOLD - 1; g++) run_seq(4, 1, 1, g, 3, "R6 restart wdog->supply", 1);
    for (int g = 1; g <= HOLD - 1; g++) run_seq(2, 3, 2, g, 2, "R6 restart manual->manual", 2);

    // R9: chattering pushbutton, pattern bit k is the level driven after edge k (1 = pressed)
    pat = 12'b0001_0110_1011;
    last_on = 0;
    for (int k = 0; k < 12; k++) if (pat[k]) last_on = k;
    begin
      int rise_k = -1, fk = -1;
      @(negedge clk);
      man_rst_n = !pat[0];
      for (int k = 1; k <= 12 + HOLD + 10; k++) begin
        @(negedge clk);
        if (sys_rst && rise_k < 0) rise_k = k;
        if (!sys_rst && rise_k > 0 && fk < 0) fk = k;
        man_rst_n = (k < 12) ? !pat[k] : 1'b1;
      end
      check(rise_k == 3, "R9 bounce onset edge", rise_k, 3);
      check(fk == last_on + 1 + HOLD + 2, "R9 bounce single release", fk, last_on + 1 + HOLD + 2);
      check(rst_cause == 2'b10, "R9 bounce cause", int'(rst_cause), 2);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule